// File: doc/BRIEF.md
# Cache Line Refill Buffer

This block gathers the words of one cache line while a miss is being serviced. A miss handler opens a fill by presenting the line address. Refill words then arrive from the external bus one at a time, each tagged with its word offset, in any order. Each word is stored in its slot and marked present. When every slot is present, the block emits the whole line and its address to the cache data array for one cycle and returns to idle.

While a fill is open, the core's lookup address is compared against the buffer in the same cycle as the cache arrays are read. If the lookup falls in the line being filled and the addressed word has already arrived, the buffer reports a hit and returns that word combinationally. The core can therefore consume refill data before the line reaches the cache. The block reports busy for as long as a fill is open, and a miss handler must wait for busy to drop before it opens another fill.

The default configuration is a line of four 32-bit words, with 32-bit byte addresses. It serves a 16KB, 4-way set-associative cache.

Top module: `line_fill_buf`

## Requirements
- R1: After reset, busy, wr_en and lk_hit are all 0.
- R2: A miss_start while busy is 0 captures miss_line as the open line. busy reads 1 from the next cycle, and no word of the new line is present.
- R3: A miss_start while busy is 1 is ignored: wr_line_addr keeps the open line and busy stays 1.
- R4: A refill word (refill_vld=1) is stored in the slot given by refill_idx and marked present from the next cycle, whatever the arrival order. A refill word presented while busy is 0 is discarded.
- R5: lk_hit is 1 in the same cycle only when busy is 1, the line part of lk_waddr equals the open line, and the addressed word is present. On a hit, lk_data is that word. On a miss, lk_data is 0.
- R6: A refill to a slot that is already present replaces its data. Later lookups and the line write carry the newer word.
- R7: wr_en is a single-cycle pulse. It comes in the cycle after the last missing word is captured, and never earlier. During it, wr_line_addr is the open line and word i is at wr_line[i*WORD_W +: WORD_W].
- R8: The cycle after wr_en, busy is 0 and no word is present, so every lookup misses.
- R9: lk_waddr is a word address. Its low log2(WORDS) bits select the word, and the remaining upper bits are compared with the line address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_start | input | 1 | Request to open a fill for miss_line |
| miss_line | input | LINE_W | Line address of the miss |
| busy | output | 1 | A fill is open; new misses must wait |
| refill_vld | input | 1 | Refill word valid |
| refill_idx | input | OFF_W | Word offset of the refill word within the line |
| refill_data | input | WORD_W | Refill word |
| lk_waddr | input | WADDR_W | Core lookup word address |
| lk_hit | output | 1 | Lookup hits a present word of the open line |
| lk_data | output | WORD_W | Forwarded word on a hit, 0 otherwise |
| wr_en | output | 1 | One-cycle line write strobe to the data array |
| wr_line_addr | output | LINE_W | Line address for the line write |
| wr_line | output | WORDS*WORD_W | Line data, word i at bits i*WORD_W upward |

## Verification
The bench uses the default build: four 32-bit words per line and 32-bit addresses. With four words per line, all 24 possible arrival orders of a line can be driven. After every arrival, the bench looks up every word of the open line and of a neighbouring line, so the hit pattern and forwarded data are compared against every partial fill state. Selected orders also inject a premature miss request and a duplicate refill word, covering the ignore and overwrite rules.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef enum logic {
    LFB_IDLE = 1'b0,
    LFB_FILL = 1'b1
  } lfb_phase_e;
endpackage

// File: rtl/lfb_rst_sync.sv
module lfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
  import lfb_pkg::*;
#(
  parameter int LINE_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_start,
  input  logic [LINE_W-1:0] miss_line,
  input  logic              full,
  output logic              busy,
  output logic              accept,
  output logic              drain,
  output logic [LINE_W-1:0] line_q
);
  lfb_phase_e phase_q, phase_d;

  // next-state logic
  always_comb begin
    accept  = miss_start & (phase_q == LFB_IDLE);
    drain   = (phase_q == LFB_FILL) & full;
    phase_d = phase_q;
    case (phase_q)
      LFB_IDLE: if (accept) phase_d = LFB_FILL;
      LFB_FILL: if (drain)  phase_d = LFB_IDLE;
      default:              phase_d = LFB_IDLE;
    endcase
  end

  // state and line-address registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= LFB_IDLE;
      line_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) line_q <= miss_line;
    end
  end

  assign busy = (phase_q == LFB_FILL);
endmodule

// File: rtl/lfb_store.sv
module lfb_store #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busy,
  input  logic                    clear,
  input  logic                    wr_vld,
  input  logic [OFF_W-1:0]        wr_idx,
  input  logic [WORD_W-1:0]       wr_data,
  output logic [WORDS-1:0]        valid,
  output logic [WORDS*WORD_W-1:0] line,
  output logic                    full
);
  for (genvar i = 0; i < WORDS; i++) begin : g_slot
    logic              we;
    logic              v_d;
    logic              v_q;
    logic [WORD_W-1:0] w_q;

    assign we = busy & wr_vld & (wr_idx == OFF_W'(i));

    always_comb begin
      if (clear)   v_d = 1'b0;
      else if (we) v_d = 1'b1;
      else         v_d = v_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    // datapath word: enable only, no reset needed
    always_ff @(posedge clk) begin
      if (we) w_q <= wr_data;
    end

    assign valid[i]                   = v_q;
    assign line[i*WORD_W +: WORD_W]   = w_q;
  end

  assign full = &valid;
endmodule

// File: rtl/lfb_probe.sv
module lfb_probe #(
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32,
  parameter int OFF_W   = 2,
  parameter int WADDR_W = 30,
  parameter int LINE_W  = 28
) (
  input  logic                    busy,
  input  logic [LINE_W-1:0]       line_q,
  input  logic [WORDS-1:0]        valid,
  input  logic [WORDS*WORD_W-1:0] line,
  input  logic [WADDR_W-1:0]      lk_waddr,
  output logic                    hit,
  output logic [WORD_W-1:0]       data
);
  logic [OFF_W-1:0]  idx;
  logic [LINE_W-1:0] tag;
  logic [WORD_W-1:0] sel;
  logic              present;

  assign idx = lk_waddr[OFF_W-1:0];
  assign tag = lk_waddr[WADDR_W-1:OFF_W];

  always_comb begin
    sel     = '0;
    present = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      if (idx == OFF_W'(i)) begin
        sel     = line[i*WORD_W +: WORD_W];
        present = valid[i];
      end
    end
  end

  assign hit  = busy & (tag == line_q) & present;
  assign data = hit ? sel : '0;
endmodule

// File: rtl/line_fill_buf.sv
module line_fill_buf #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int BOFF_W  = $clog2(WORD_W / 8),
  localparam int WADDR_W = ADDR_W - BOFF_W,
  localparam int LINE_W  = WADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_start,
  input  logic [LINE_W-1:0]       miss_line,
  output logic                    busy,
  input  logic                    refill_vld,
  input  logic [OFF_W-1:0]        refill_idx,
  input  logic [WORD_W-1:0]       refill_data,
  input  logic [WADDR_W-1:0]      lk_waddr,
  output logic                    lk_hit,
  output logic [WORD_W-1:0]       lk_data,
  output logic                    wr_en,
  output logic [LINE_W-1:0]       wr_line_addr,
  output logic [WORDS*WORD_W-1:0] wr_line
);
  logic              rst_n_s;
  logic              accept;
  logic              full;
  logic [WORDS-1:0]  valid;
  logic [LINE_W-1:0] line_q;

  lfb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lfb_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .miss_start (miss_start),
    .miss_line  (miss_line),
    .full       (full),
    .busy       (busy),
    .accept     (accept),
    .drain      (wr_en),
    .line_q     (line_q)
  );

  lfb_store #(.WORDS(WORDS), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .busy    (busy),
    .clear   (accept | wr_en),
    .wr_vld  (refill_vld),
    .wr_idx  (refill_idx),
    .wr_data (refill_data),
    .valid   (valid),
    .line    (wr_line),
    .full    (full)
  );

  lfb_probe #(
    .WORDS(WORDS), .WORD_W(WORD_W), .OFF_W(OFF_W),
    .WADDR_W(WADDR_W), .LINE_W(LINE_W)
  ) u_probe (
    .busy     (busy),
    .line_q   (line_q),
    .valid    (valid),
    .line     (wr_line),
    .lk_waddr (lk_waddr),
    .hit      (lk_hit),
    .data     (lk_data)
  );

  assign wr_line_addr = line_q;
endmodule

// File: rtl/lfb_checker.sv
module lfb_checker #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int BOFF_W  = $clog2(WORD_W / 8),
  localparam int WADDR_W = ADDR_W - BOFF_W,
  localparam int LINE_W  = WADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_start,
  input logic              busy,
  input logic              lk_hit,
  input logic [WORD_W-1:0] lk_data,
  input logic              wr_en,
  input logic [LINE_W-1:0] wr_line_addr
);
  AST_OPEN_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start && !busy) |=> busy); // R2

  AST_OPEN_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_en) |=> (busy && $stable(wr_line_addr))); // R3

  AST_HIT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> busy); // R5

  AST_MISS_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_data == '0)); // R5

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R7

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy); // R7

  AST_WRITE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !busy); // R8
endmodule

bind line_fill_buf lfb_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)
) u_chk (.*);

// File: tb/line_fill_buf_tb.sv
`timescale 1ns/1ps
module line_fill_buf_tb;
  localparam int ADDR_W  = 32;
  localparam int WORD_W  = 32;
  localparam int WORDS   = 4;
  localparam int OFF_W   = 2;
  localparam int WADDR_W = 30;
  localparam int LINE_W  = 28;

  logic                    clk;
  logic                    rst_n;
  logic                    miss_start;
  logic [LINE_W-1:0]       miss_line;
  logic                    busy;
  logic                    refill_vld;
  logic [OFF_W-1:0]        refill_idx;
  logic [WORD_W-1:0]       refill_data;
  logic [WADDR_W-1:0]      lk_waddr;
  logic                    lk_hit;
  logic [WORD_W-1:0]       lk_data;
  logic                    wr_en;
  logic [LINE_W-1:0]       wr_line_addr;
  logic [WORDS*WORD_W-1:0] wr_line;

  line_fill_buf #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  logic [WORD_W-1:0] expw [WORDS];
  bit                got  [WORDS];
  bit                active;

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [WORD_W-1:0] mkw(input logic [LINE_W-1:0] ln,
                                            input int tg, input int ix);
    return {ln[15:0], 8'(tg), 8'(ix)};
  endfunction

  task automatic look(input logic [LINE_W-1:0] ln, input int j,
                      input bit eh, input logic [WORD_W-1:0] ed, input string req);
    lk_waddr = {ln, OFF_W'(j)};
    #0.2;
    chk(lk_hit == eh, req, lk_hit, eh);
    chk(lk_data == ed, req, lk_data, ed);
  endtask

  // every word of the open line, plus the neighbouring line (R9 decode)
  task automatic look_all(input logic [LINE_W-1:0] ln, input string req);
    for (int j = 0; j < WORDS; j++) begin
      look(ln, j, active && got[j], (active && got[j]) ? expw[j] : '0, req);
      look(ln ^ LINE_W'(1), j, 1'b0, '0, "R9 foreign line");
    end
  endtask

  task automatic do_fill(input logic [LINE_W-1:0] ln, input int ord [WORDS],
                         input int tg, input int mode);
    logic [WORDS*WORD_W-1:0] expl;
    miss_line  = ln;
    miss_start = 1'b1;
    tick;
    miss_start = 1'b0;
    chk(busy == 1'b1, "R2 busy after open", busy, 1);
    active = 1;
    for (int j = 0; j < WORDS; j++) got[j] = 0;
    look_all(ln, "R2 R4 nothing present");
    for (int k = 0; k < WORDS; k++) begin
      refill_idx  = OFF_W'(ord[k]);
      refill_data = mkw(ln, tg, ord[k]);
      refill_vld  = 1'b1;
      tick;
      refill_vld  = 1'b0;
      expw[ord[k]] = mkw(ln, tg, ord[k]);
      got[ord[k]]  = 1;
      if (k < WORDS - 1) begin
        chk(wr_en == 1'b0, "R7 no early write", wr_en, 0);
        look_all(ln, "R4 R5 partial fill");
      end
      if (mode == 2 && k == 1) begin
        refill_idx  = OFF_W'(ord[0]);
        refill_data = ~mkw(ln, tg, ord[0]);
        refill_vld  = 1'b1;
        tick;
        refill_vld  = 1'b0;
        expw[ord[0]] = ~mkw(ln, tg, ord[0]);
        chk(wr_en == 1'b0, "R6 rewrite no write", wr_en, 0);
        look_all(ln, "R6 overwrite");
      end
      if (mode == 1 && k == 2) begin
        miss_line  = ln ^ LINE_W'(5);
        miss_start = 1'b1;
        tick;
        miss_start = 1'b0;
        chk(busy == 1'b1, "R3 busy kept", busy, 1);
        chk(wr_line_addr == ln, "R3 line kept", wr_line_addr, ln);
        look_all(ln, "R3 words kept");
      end
    end
    for (int i = 0; i < WORDS; i++) expl[i*WORD_W +: WORD_W] = expw[i];
    chk(wr_en == 1'b1, "R7 write strobe", wr_en, 1);
    chk(wr_line_addr == ln, "R7 write address", wr_line_addr, ln);
    chk(wr_line == expl, "R7 write data", wr_line, expl);
    look_all(ln, "R5 full line");
    tick;
    chk(wr_en == 1'b0, "R7 single pulse", wr_en, 0);
    chk(busy == 1'b0, "R8 idle after write", busy, 0);
    active = 0;
    look_all(ln, "R8 all miss");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int p;
    int ord [WORDS];
    rst_n       = 1'b0;
    miss_start  = 1'b0;
    miss_line   = '0;
    refill_vld  = 1'b0;
    refill_idx  = '0;
    refill_data = '0;
    lk_waddr    = '0;
    active      = 0;
    for (int j = 0; j < WORDS; j++) begin got[j] = 0; expw[j] = '0; end
    repeat (3) tick;
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(wr_en == 1'b0, "R1 wr_en in reset", wr_en, 0);
    chk(lk_hit == 1'b0, "R1 hit in reset", lk_hit, 0);
    rst_n = 1'b1;
    repeat (3) tick;
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);

    // R4: refill while idle is discarded; first fill then shows word 2 absent
    refill_idx  = 2'd2;
    refill_data = 32'hDEAD_BEEF;
    refill_vld  = 1'b1;
    tick;
    refill_vld  = 1'b0;
    chk(busy == 1'b0, "R4 idle refill ignored", busy, 0);

    p = 0;
    for (int a = 0; a < 256; a++) begin
      logic [3:0] seen;
      seen = '0;
      for (int k = 0; k < WORDS; k++) begin
        ord[k] = (a >> (2 * k)) & 3;
        seen[ord[k]] = 1'b1;
      end
      if (seen == 4'hF) begin
        do_fill(LINE_W'(28'h0A0_0000 + p * 3), ord, p,
                (p == 0) ? 1 : (p == 1) ? 2 : 0);
        p++;
      end
    end
    chk(p == 24, "R4 all orders run", p, 24);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule